// File: doc/BRIEF.md
# Streaming Binary Contour Extractor

This block takes a single-object binary image streamed in raster order, one pixel per clock, and returns an image of the same size in which only the object's contour remains. A pixel survives when it is set in the input but would be removed by a 3x3 erosion. The erosion keeps a pixel only when all nine pixels of its neighbourhood are set. The erosion and the subtraction are fused into one streaming stage, so the output is the one-pixel-wide contour and never the eroded image.

Two line stores of one image row each hold the rows above the current one. Each input pixel therefore enters the block exactly once. Both line stores are addressed by the same column counter. A pixel's result leaves the block one row plus one pixel after it enters. Once the last pixel of a frame has been accepted, the block produces the final row and one extra pixel of its own, padding with background. Positions outside the image count as background, so object pixels on the image edge are always contour pixels. Image width and height are parameters, with a default of 512 by 512.

Top module: `bnd_extract`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after that edge, `out_valid`, `out_sof` and `out_pix` are all 0.
- R2: Before the first accepted start of frame (`in_valid` and `in_sof` both 1), pixels offered with `in_valid`=1 and `in_sof`=0 are dropped and produce no output.
- R3: For a pixel at row r and column c, `out_pix` is 1 exactly when the input pixel is 1 and at least one of its eight neighbours is 0. In every cycle where `out_valid` is 0, `out_pix` is 0.
- R4: A neighbour position outside the image (row -1, row H, column -1 or column W) counts as 0. Every object pixel in row 0, row H-1, column 0 or column W-1 is therefore a contour pixel.
- R5: Number pixels by raster index n = r*W + c, with pixel 0 marked by `in_sof`. The result for pixel n is presented in the cycle after the clock edge that accepts input pixel n+W+1. The final W+1 results follow on consecutive cycles after the edge that accepts pixel W*H-1. The source keeps `in_valid` at 0 during those W+1 cycles.
- R6: Each frame produces exactly W*H cycles with `out_valid`=1, in raster order. `out_sof` is 1 only together with the result for row 0, column 0.
- R7: Within a frame, a cycle with `in_valid`=0 produces no output and does not change any later result.
- R8: The result of a frame depends only on that frame's pixels. Pixels left in the line stores from an earlier frame have no effect.
- R9: `in_pix` and `in_sof` are ignored in any cycle where `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The input pixel is present this cycle |
| in_sof | input | 1 | The input pixel is row 0, column 0 of a new frame |
| in_pix | input | 1 | Input pixel: 1 = object, 0 = background |
| out_valid | output | 1 | A contour result is present this cycle |
| out_sof | output | 1 | The result is for row 0, column 0 |
| out_pix | output | 1 | 1 = the pixel is on the object's contour |

## Verification
The checker assumes that every frame is delivered complete, with W*H accepted pixels and `in_sof` only on the first one. It also assumes that `in_valid` stays low for the W+1 cycles in which the block pads the last row. Under these assumptions it can relate each accepted input index to an output in the next cycle. The bench keeps within these rules: it always streams whole frames, inserts random idle cycles only between pixels of a frame, and follows each frame with more than W+1 idle cycles. In those idle cycles it drives random values on `in_pix` and `in_sof` with `in_valid` held low.

// File: rtl/bnd_pkg.sv
// Package: shared types and constants for the streaming contour extractor.
// Assumes a 3x3 neighbourhood, which needs two buffered rows above the
// incoming row.
package bnd_pkg;

    // Neighbourhood edge length and number of buffered rows it implies
    localparam int WIN     = 3;
    localparam int N_LINES = WIN - 1;

    // Frame sequencing phases
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,   // waiting for a start of frame
        SEQ_RUN   = 2'd1,   // accepting pixels of a frame
        SEQ_FLUSH = 2'd2    // padding the last row with background
    } seq_state_t;

    // Which sides of the window around the centre pixel lie outside the image
    typedef struct packed {
        logic top;
        logic bot;
        logic left;
        logic right;
    } edge_mask_t;

endpackage

// File: rtl/bnd_linebuf.sv
// Module: one image row of single-bit storage.
// Write is synchronous. Read is asynchronous at the same column address,
// so a read in a cycle returns the value written one row earlier, before
// the write of that cycle takes effect.
// Assumes DEPTH >= 2.
module bnd_linebuf #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic          wr_bit,
    output logic          rd_bit
);

    logic mem [DEPTH];

    // Store the incoming bit at the current column when the stream advances
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_bit;
        end
    end

    // Present the bit stored one row ago at this column
    assign rd_bit = mem[addr];

endmodule

// File: rtl/bnd_seq.sv
// Module: frame sequencer.
// Tracks the raster position of the next incoming pixel. Decides when the
// stream advances: on an accepted pixel, or by itself while it pads the end
// of a frame. Works out where the window centre sits (one row plus one
// pixel behind the input) and which window sides fall outside the image.
// Assumes the source keeps in_valid low during padding and sends whole frames.
module bnd_seq
    import bnd_pkg::*;
#(
    parameter int IMG_W = 512,
    parameter int IMG_H = 512,
    localparam int CW   = $clog2(IMG_W),
    localparam int RW   = $clog2(IMG_H + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    output logic          step,
    output logic          flushing,
    output logic [CW-1:0] col_addr,
    output edge_mask_t    mask,
    output logic          ctr_ok,
    output logic          ctr_first
);

    localparam logic [CW-1:0] COL_LAST  = CW'(IMG_W - 1);
    localparam logic [RW-1:0] ROW_LAST  = RW'(IMG_H - 1);
    localparam logic [RW-1:0] ROW_FLEND = RW'(IMG_H + 1);

    seq_state_t    state_q, state_nx;
    logic [CW-1:0] pos_col_q;
    logic [RW-1:0] pos_row_q;

    logic          accept, restart, last_px, flush_end, wrap;
    logic [CW-1:0] cur_col, nxt_col, ctr_col;
    logic [RW-1:0] cur_row, nxt_row, ctr_row;

    // Accept a pixel that starts a frame, or any valid pixel inside a frame
    always_comb begin
        accept  = in_valid && (state_q != SEQ_FLUSH)
                  && (in_sof || (state_q == SEQ_RUN));
        restart = accept && in_sof;
        step    = accept || (state_q == SEQ_FLUSH);
    end

    // Position of the pixel entering the window on this step
    always_comb begin
        cur_col = restart ? '0 : pos_col_q;
        cur_row = restart ? '0 : pos_row_q;
    end

    // Raster increment of the entry position
    always_comb begin
        if (cur_col == COL_LAST) begin
            nxt_col = '0;
            nxt_row = cur_row + RW'(1);
        end else begin
            nxt_col = cur_col + CW'(1);
            nxt_row = cur_row;
        end
    end

    // Frame boundary events
    always_comb begin
        last_px   = accept && (cur_col == COL_LAST) && (cur_row == ROW_LAST);
        flush_end = (state_q == SEQ_FLUSH) && (cur_row == ROW_FLEND);
    end

    // Phase transitions: the end of a frame outranks a restart
    always_comb begin
        state_nx = state_q;
        if (last_px) begin
            state_nx = SEQ_FLUSH;
        end else if (flush_end) begin
            state_nx = SEQ_IDLE;
        end else if (restart) begin
            state_nx = SEQ_RUN;
        end
    end

    // Phase and entry position registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            pos_col_q <= '0;
            pos_row_q <= '0;
        end else begin
            state_q <= state_nx;
            if (step) begin
                pos_col_q <= nxt_col;
                pos_row_q <= nxt_row;
            end
        end
    end

    // Window centre lies W+1 steps behind the entry position
    always_comb begin
        wrap    = (cur_col == '0);
        ctr_col = wrap ? COL_LAST : (cur_col - CW'(1));
        ctr_row = wrap ? (cur_row - RW'(2)) : (cur_row - RW'(1));
        ctr_ok  = step && (wrap ? (cur_row >= RW'(2)) : (cur_row >= RW'(1)));
    end

    // Sides of the window outside the image, and the first centre of a frame
    always_comb begin
        mask.top   = (ctr_row == '0);
        mask.bot   = (ctr_row == ROW_LAST);
        mask.left  = (ctr_col == '0);
        mask.right = (ctr_col == COL_LAST);
        ctr_first  = ctr_ok && mask.top && mask.left;
    end

    assign flushing = (state_q == SEQ_FLUSH);
    assign col_addr = cur_col;

endmodule

// File: rtl/bnd_window.sv
// Module: 3x3 window, fused erosion and subtraction, and output register.
// Holds the two previous pixel columns and combines them with the column
// entering on this step. Clears the window positions that lie outside the
// image, then marks the centre as contour when it is set and not every
// position of the window is set.
// Column bit 0 is the oldest row (top) and the top bit is the newest (bottom).
module bnd_window
    import bnd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic [WIN-1:0] col_in,
    input  edge_mask_t     mask,
    input  logic           ctr_ok,
    input  logic           ctr_first,
    output logic           out_valid,
    output logic           out_sof,
    output logic           out_pix
);

    localparam int HIST = WIN - 1;
    localparam int MID  = WIN / 2;

    logic [WIN-1:0]     hist_q [HIST];
    logic [WIN-1:0]     win    [WIN];
    logic [WIN*WIN-1:0] nb;
    logic               centre, eroded, contour;

    // Shift the column history when the stream advances
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < HIST; k++) begin
                hist_q[k] <= '0;
            end
        end else if (step) begin
            hist_q[0] <= col_in;
            for (int k = 1; k < HIST; k++) begin
                hist_q[k] <= hist_q[k-1];
            end
        end
    end

    // Assemble the window: leftmost column is the oldest history entry
    always_comb begin
        win[WIN-1] = col_in;
        for (int c = 0; c < WIN - 1; c++) begin
            win[c] = hist_q[WIN-2-c];
        end
    end

    // Clear the positions outside the image, then erode and subtract
    always_comb begin
        for (int r = 0; r < WIN; r++) begin
            for (int c = 0; c < WIN; c++) begin
                nb[r*WIN+c] = win[c][r]
                              & ~((r == 0)       && mask.top)
                              & ~((r == WIN - 1) && mask.bot)
                              & ~((c == 0)       && mask.left)
                              & ~((c == WIN - 1) && mask.right);
            end
        end
        centre  = win[MID][MID];
        eroded  = &nb;
        contour = centre & ~eroded;
    end

    // Register the result of the centre pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_pix   <= 1'b0;
        end else begin
            out_valid <= ctr_ok;
            out_sof   <= ctr_first;
            out_pix   <= ctr_ok & contour;
        end
    end

endmodule

// File: rtl/bnd_extract.sv
// Module: streaming binary contour extractor (top).
// Takes a binary image in raster order, one pixel per accepted cycle, and
// emits the pixels that a 3x3 erosion would remove. The result of a pixel
// leaves one row plus one pixel after the pixel enters.
// Assumes whole frames and an idle source during the W+1 padding cycles.
module bnd_extract
    import bnd_pkg::*;
#(
    parameter int IMG_W = 512,
    parameter int IMG_H = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_pix,
    output logic out_valid,
    output logic out_sof,
    output logic out_pix
);

    localparam int CW = $clog2(IMG_W);

    logic             step, flushing, ctr_ok, ctr_first;
    logic [CW-1:0]    col_addr;
    edge_mask_t       mask;
    logic [N_LINES:0] tap;
    logic [WIN-1:0]   col_vec;

    bnd_seq #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .step      (step),
        .flushing  (flushing),
        .col_addr  (col_addr),
        .mask      (mask),
        .ctr_ok    (ctr_ok),
        .ctr_first (ctr_first)
    );

    // Pixel entering the window: background while padding the frame end
    assign tap[0] = flushing ? 1'b0 : in_pix;

    // Chain of row stores: each one delays its input by one image row
    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        bnd_linebuf #(
            .DEPTH (IMG_W)
        ) u_lb (
            .clk    (clk),
            .wr_en  (step),
            .addr   (col_addr),
            .wr_bit (tap[k]),
            .rd_bit (tap[k+1])
        );
    end

    // Newest row at the top bit of the column, oldest at bit 0
    for (genvar k = 0; k <= N_LINES; k++) begin : g_col
        assign col_vec[N_LINES-k] = tap[k];
    end

    bnd_window u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .col_in    (col_vec),
        .mask      (mask),
        .ctr_ok    (ctr_ok),
        .ctr_first (ctr_first),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_pix   (out_pix)
    );

endmodule

// File: rtl/bnd_extract_chk.sv
// Module: property checker for the contour extractor, bound to its top.
// Follows the frame at the ports only: it counts accepted input pixels,
// padding cycles and output results, and relates them over time.
// Assumes whole frames and in_sof only on the first pixel of each frame.
module bnd_extract_chk #(
    parameter int IMG_W = 512,
    parameter int IMG_H = 512
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_sof,
    input logic out_valid,
    input logic out_sof,
    input logic out_pix
);

    localparam int TOTAL = IMG_W * IMG_H;
    localparam int NW    = $clog2(TOTAL + 1);
    localparam int FW    = $clog2(IMG_W + 2);

    logic          seen_q, in_active_q, out_started_q;
    logic [NW-1:0] in_cnt_q, out_cnt_q, idx;
    logic [FW-1:0] flush_left_q;
    logic          acc;

    // Index of the pixel offered this cycle, and whether the block takes it
    always_comb begin
        idx = in_sof ? '0 : in_cnt_q;
        acc = in_valid && (in_sof ? (flush_left_q == '0) : in_active_q);
    end

    // Input side bookkeeping: pixels taken and padding cycles left
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q       <= 1'b0;
            in_active_q  <= 1'b0;
            in_cnt_q     <= '0;
            flush_left_q <= '0;
        end else begin
            seen_q <= seen_q | (in_valid & in_sof);
            if (acc) begin
                in_cnt_q    <= idx + NW'(1);
                in_active_q <= ((idx + NW'(1)) != NW'(TOTAL));
                if ((idx + NW'(1)) == NW'(TOTAL)) begin
                    flush_left_q <= FW'(IMG_W + 1);
                end
            end else if (flush_left_q != '0) begin
                flush_left_q <= flush_left_q - FW'(1);
            end
        end
    end

    // Output side bookkeeping: results seen since the last out_sof
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cnt_q     <= '0;
            out_started_q <= 1'b0;
        end else if (out_valid) begin
            out_cnt_q     <= out_sof ? NW'(1) : (out_cnt_q + NW'(1));
            out_started_q <= out_started_q | out_sof;
        end
    end

    p_pix_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_pix |-> out_valid);

    p_sof_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    p_quiet_before_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |=> !out_valid);

    p_no_input_in_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_left_q != '0) |-> !in_valid);

    p_out_follows_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (idx >= NW'(IMG_W + 1))) |=> out_valid);

    p_no_early_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (idx < NW'(IMG_W + 1))) |=> !out_valid);

    p_pad_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_left_q != '0) |=> out_valid);

    p_stall_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_active_q && !in_valid && (flush_left_q == '0)) |=> !out_valid);

    p_frame_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> (out_started_q && (out_cnt_q < NW'(TOTAL))));

    p_frame_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (!out_started_q || (out_cnt_q == NW'(TOTAL))));

endmodule

bind bnd_extract bnd_extract_chk #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H)
) u_chk (.*);

// File: tb/bnd_extract_tb.sv
// Bench: streams stored frames through the contour extractor and compares
// every clock against a behavioural model. The model keeps counters for
// expected timing and computes the contour directly from the stored frame.
module bnd_extract_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 9;
    localparam int H          = 7;
    localparam int TOTAL      = W * H;

    logic clk = 1'b0;
    logic rst_n, in_valid, in_sof, in_pix;
    logic out_valid, out_sof, out_pix;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R1";

    bit    fr [TOTAL];

    // Model state: 0 idle, 1 in frame, 2 padding
    int m_state = 0, m_cnt = 0, m_flush = 0;
    bit exp_valid = 0;
    int exp_idx = 0;
    int act_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bnd_extract #(.IMG_W(W), .IMG_H(H)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_pix   (out_pix)
    );

    // Contour rule from R3/R4: set, and some neighbour (outside = 0) clear
    function automatic bit ref_bit(input int i);
        int r, c;
        bit all_set;
        r = i / W;
        c = i % W;
        if (!fr[i]) return 1'b0;
        all_set = 1'b1;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                if ((r+dr) < 0 || (r+dr) >= H || (c+dc) < 0 || (c+dc) >= W)
                    all_set = 1'b0;
                else if (!fr[(r+dr)*W + (c+dc)])
                    all_set = 1'b0;
            end
        end
        return !all_set;
    endfunction

    function automatic bit on_border(input int i);
        return (i / W == 0) || (i / W == H-1) || (i % W == 0) || (i % W == W-1);
    endfunction

    // Timing model from R5: result n follows the accept of pixel n+W+1
    task automatic model_edge(input logic v, input logic s);
        int idx;
        exp_valid = 1'b0;
        if (m_state == 2) begin
            exp_valid = 1'b1;
            exp_idx   = TOTAL - m_flush;
            m_flush--;
            if (m_flush == 0) m_state = 0;
        end else if (v && (s || m_state == 1)) begin
            idx     = s ? 0 : m_cnt;
            m_state = 1;
            m_cnt   = idx + 1;
            if (idx >= W + 1) begin
                exp_valid = 1'b1;
                exp_idx   = idx - (W + 1);
            end
            if (m_cnt == TOTAL) begin
                m_state = 2;
                m_flush = W + 1;
            end
        end
    endtask

    task automatic check_outputs();
        bit    e_pix, e_sof;
        string tag;
        e_pix = exp_valid ? ref_bit(exp_idx) : 1'b0;
        e_sof = exp_valid && (exp_idx == 0);
        n_tests++;
        if (out_valid) act_cnt++;
        if (out_valid !== exp_valid || out_sof !== e_sof || out_pix !== e_pix) begin
            if (out_valid !== exp_valid) tag = cur_tag;
            else if (out_sof !== e_sof) tag = "R6";
            else if (on_border(exp_idx)) tag = "R4";
            else tag = "R3";
            n_fail++;
            $display("FAIL %s (%s) idx=%0d: valid/sof/pix = %0b%0b%0b, expected %0b%0b%0b",
                     tag, cur_tag, exp_idx, out_valid, out_sof, out_pix,
                     exp_valid, e_sof, e_pix);
        end
    endtask

    // One clock: drive, let the edge happen, update the model, check away from it
    task automatic cycle(input logic v, input logic s, input logic p);
        in_valid = v;
        in_sof   = s;
        in_pix   = p;
        @(posedge clk);
        model_edge(v, s);
        @(negedge clk);
        check_outputs();
    endtask

    // Idle cycles with junk on in_pix and in_sof (R9)
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            cycle(1'b0, 1'($urandom % 2), 1'($urandom % 2));
        end
    endtask

    // Stream a whole frame, optionally with stalls (R7), then pad and count (R6)
    task automatic stream_frame(input bit gaps);
        act_cnt = 0;
        for (int i = 0; i < TOTAL; i++) begin
            if (gaps) idle($urandom % 3);
            cycle(1'b1, (i == 0), fr[i]);
        end
        idle(W + 4);
        n_tests++;
        if (act_cnt != TOTAL) begin
            n_fail++;
            $display("FAIL R6 output count per frame: %0d, expected %0d", act_cnt, TOTAL);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: %0d, expected completion", n_tests);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_pix = 1'b0;
        // R1: outputs held low during reset, even with input offered
        repeat (3) begin
            in_valid = 1'b1; in_sof = 1'b1; in_pix = 1'b1;
            @(posedge clk);
            @(negedge clk);
            n_tests++;
            if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_pix !== 1'b0) begin
                n_fail++;
                $display("FAIL R1 in reset: %0b%0b%0b, expected 000",
                         out_valid, out_sof, out_pix);
            end
        end
        in_valid = 1'b0; in_sof = 1'b0;
        rst_n = 1'b1;
        cur_tag = "R1";
        idle(2);

        // R2: pixels before any start of frame are dropped
        cur_tag = "R2";
        for (int k = 0; k < 2*W; k++) cycle(1'b1, 1'b0, 1'b1);

        // R3/R4/R5: random object
        cur_tag = "R5";
        for (int i = 0; i < TOTAL; i++) fr[i] = (($urandom % 10) < 7);
        stream_frame(1'b0);

        // R4: full image, only the edge ring is contour
        for (int i = 0; i < TOTAL; i++) fr[i] = 1'b1;
        stream_frame(1'b0);

        // R8: same full image again after a full one; then an empty image
        cur_tag = "R8";
        stream_frame(1'b0);
        for (int i = 0; i < TOTAL; i++) fr[i] = 1'b0;
        stream_frame(1'b0);

        // R3/R7: block object plus an isolated pixel, streamed with stalls
        cur_tag = "R7";
        for (int i = 0; i < TOTAL; i++)
            fr[i] = ((i / W) >= 1 && (i / W) <= 5 && (i % W) >= 2 && (i % W) <= 7);
        fr[0] = 1'b1;
        stream_frame(1'b1);

        // R9/R7: random object with stalls carrying junk inputs
        cur_tag = "R9";
        for (int i = 0; i < TOTAL; i++) fr[i] = (($urandom % 10) < 6);
        stream_frame(1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule